// File: doc/BRIEF.md
# Timed-Access Software Reset Generator

This block lets firmware reset the chip on purpose while making an accidental reset very unlikely. It sits on a byte-wide register bus and has two registers. The first is a key register. A fixed three-byte pattern written to it opens a gate for exactly one write to the second register, the fire register. Only the byte FFh written through that open gate starts a reset. Any other byte is dropped, and the gate closes either way.

The reset output is stretched. Its length is a number of millisecond ticks, chosen by a static 3-bit duration code. The same stretcher also serves the power-on reset and an external reset request, so every reset source reaches the chip through one timed output. The fire register reads FFh while a software reset runs. It clears itself on the cycle the reset ends. While the reset is active, the unlock state is held cleared and bus writes have no effect.

Top module: `swrst_gen`

## Requirements
- R1: While `arst_n` is low, `rst_out` is high. After `arst_n` is released, `rst_out` stays high for exactly the selected number of `tick_ms` edges. During this time the fire register reads 00h.
- R2: Writing 55h, AAh and 5Ah in that order to the key register (address KEY_ADDR) opens the gate for one write to the fire register (address FIRE_ADDR).
- R3: When the gate is closed, a write to the fire register has no effect. The register keeps reading 00h and `rst_out` stays low.
- R4: A wrong byte in the key sequence sends the sequence back to its start. If that wrong byte is 55h, it counts as a new first byte, so 55h 55h AAh 5Ah opens the gate.
- R5: Writing FFh through the open gate raises `rst_out` from the clock edge that takes the write. The fire register then reads FFh until the reset ends.
- R6: Writing any byte from 00h to FEh through the open gate starts no reset and leaves the fire register at 00h. The gate closes after this write.
- R7: The duration code `dur_sel` selects the stretch length in ticks: 0 gives 25, 1 gives 200, 2 gives 100, 3 gives 50, 4 gives 16, 5 gives 8, 6 gives 4 and 7 gives 2. A reset ends on the tick edge that completes this count. The clock edge that starts a reset does not count as a tick.
- R8: The fire register returns to 00h on the same edge on which `rst_out` falls.
- R9: While `ext_rst_req` is high, `rst_out` is high and the count is held at zero. After the request is released, `rst_out` stays high for exactly the selected number of ticks.
- R10: While `rst_out` or `ext_rst_req` is high, bus writes to the key register are ignored and the unlock state is cleared. A gate opened before a reset is therefore closed after it.
- R11: Writes to other addresses, and writes to the fire register while the gate is closed, leave the key-sequence progress unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_req | input | 1 | External reset request, synchronous, active high |
| tick_ms | input | 1 | One-cycle enable pulse each millisecond |
| dur_sel | input | 3 | Static reset duration code |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address for both reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data: the fire register at FIRE_ADDR, 00h at any other address |
| rst_out | output | 1 | Stretched reset output, active high |

## Verification
Two functions can act in the same cycle: a software trigger write and a rising external request. The bench produces this by opening the gate and then driving `ext_rst_req` high on the same edge that carries the FFh write. The expected result is a fire register reading FFh for the whole reset, a stretch of exactly the selected number of ticks counted from the release of the request, and a register back at 00h when the output falls. A second overlap is a tick on the edge that starts a reset. The bench only counts tick edges taken while `rst_out` was already high, so a starting tick counted by mistake shows up as a pulse one tick short.

// File: rtl/swr_pkg.sv
package swr_pkg;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned MAX_MS  = 200;
  localparam int unsigned CNT_W   = $clog2(MAX_MS + 1);

  localparam logic [BYTE_W-1:0] KEY_FIRST  = 8'h55;
  localparam logic [BYTE_W-1:0] KEY_SECOND = 8'hAA;
  localparam logic [BYTE_W-1:0] KEY_THIRD  = 8'h5A;
  localparam logic [BYTE_W-1:0] FIRE_BYTE  = 8'hFF;
  localparam logic [BYTE_W-1:0] IDLE_BYTE  = 8'h00;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ONE  = 2'd1,
    SEQ_TWO  = 2'd2,
    SEQ_OPEN = 2'd3
  } seq_e;

  // Stretch length in millisecond ticks for a duration code.
  function automatic logic [CNT_W-1:0] stretch_ms(input logic [SEL_W-1:0] sel);
    logic [CNT_W-1:0] v;
    case (sel)
      3'd0:    v = CNT_W'(25);
      3'd1:    v = CNT_W'(200);
      3'd2:    v = CNT_W'(100);
      3'd3:    v = CNT_W'(50);
      3'd4:    v = CNT_W'(16);
      3'd5:    v = CNT_W'(8);
      3'd6:    v = CNT_W'(4);
      default: v = CNT_W'(2);
    endcase
    return v;
  endfunction

  // Next state of the key sequence for one byte written to the key register.
  function automatic seq_e seq_step(input seq_e cur, input logic [BYTE_W-1:0] b);
    seq_e nxt;
    if (cur == SEQ_ONE && b == KEY_SECOND)     nxt = SEQ_TWO;
    else if (cur == SEQ_TWO && b == KEY_THIRD) nxt = SEQ_OPEN;
    else if (b == KEY_FIRST)                   nxt = SEQ_ONE;
    else                                       nxt = SEQ_IDLE;
    return nxt;
  endfunction

endpackage

// File: rtl/swr_unlock_seq.sv
module swr_unlock_seq
  import swr_pkg::*;
(
  input  logic              clk,
  input  logic              arst_n,
  input  logic              hold_clr,
  input  logic              key_wr,
  input  logic [BYTE_W-1:0] key_byte,
  input  logic              consume,
  output logic              gate_open,
  output logic              seq_armed
);

  seq_e state_q;
  seq_e state_d;

  always_comb begin
    state_d = state_q;
    if (hold_clr)     state_d = SEQ_IDLE;
    else if (consume) state_d = SEQ_IDLE;
    else if (key_wr)  state_d = seq_step(state_q, key_byte);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

  assign gate_open = (state_q == SEQ_OPEN);
  assign seq_armed = (state_q != SEQ_IDLE);

endmodule

// File: rtl/swr_fire_reg.sv
module swr_fire_reg
  import swr_pkg::*;
(
  input  logic              clk,
  input  logic              arst_n,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              done,
  output logic [BYTE_W-1:0] reg_val,
  output logic              fire
);

  assign fire = reg_wr && (wdata == FIRE_BYTE);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)    reg_val <= IDLE_BYTE;
    else if (done)  reg_val <= IDLE_BYTE;
    else if (fire)  reg_val <= FIRE_BYTE;
  end

endmodule

// File: rtl/swr_stretch.sv
module swr_stretch
  import swr_pkg::*;
(
  input  logic             clk,
  input  logic             arst_n,
  input  logic             start,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             active,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic             last_tick;

  assign last_tick = (cnt_q >= (limit - CNT_W'(1)));
  assign done      = active && tick && !start && last_tick;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      active <= 1'b1;
      cnt_q  <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt_q  <= '0;
    end else if (done) begin
      active <= 1'b0;
      cnt_q  <= '0;
    end else if (active && tick) begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/swrst_gen.sv
module swrst_gen
  import swr_pkg::*;
#(
  parameter logic [7:0] KEY_ADDR  = 8'hC5,
  parameter logic [7:0] FIRE_ADDR = 8'hC6
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       ext_rst_req,
  input  logic       tick_ms,
  input  logic [2:0] dur_sel,
  input  logic       bus_wr,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       rst_out
);

  logic             rst_act;
  logic             wr_ok;
  logic             key_wr;
  logic             fire_wr;
  logic             seq_open;
  logic             seq_armed;
  logic             sw_fire;
  logic             stretch_done;
  logic             hold_clr;
  logic             start;
  logic [7:0]       reg_val;
  logic [CNT_W-1:0] limit;

  assign wr_ok    = bus_wr && !rst_act;
  assign key_wr   = wr_ok && (bus_addr == KEY_ADDR);
  assign fire_wr  = wr_ok && (bus_addr == FIRE_ADDR) && seq_open;
  assign hold_clr = rst_act || ext_rst_req;
  assign start    = ext_rst_req || sw_fire;
  assign limit    = stretch_ms(dur_sel);

  swr_unlock_seq u_seq (
    .clk       (clk),
    .arst_n    (arst_n),
    .hold_clr  (hold_clr),
    .key_wr    (key_wr),
    .key_byte  (bus_wdata),
    .consume   (fire_wr),
    .gate_open (seq_open),
    .seq_armed (seq_armed)
  );

  swr_fire_reg u_reg (
    .clk     (clk),
    .arst_n  (arst_n),
    .reg_wr  (fire_wr),
    .wdata   (bus_wdata),
    .done    (stretch_done),
    .reg_val (reg_val),
    .fire    (sw_fire)
  );

  swr_stretch u_str (
    .clk    (clk),
    .arst_n (arst_n),
    .start  (start),
    .tick   (tick_ms),
    .limit  (limit),
    .active (rst_act),
    .done   (stretch_done)
  );

  assign rst_out   = rst_act;
  assign bus_rdata = (bus_addr == FIRE_ADDR) ? reg_val : IDLE_BYTE;

endmodule

// File: rtl/swrst_gen_chk.sv
module swrst_gen_chk #(
  parameter logic [7:0] FIRE_ADDR = 8'hC6
) (
  input logic       clk,
  input logic       arst_n,
  input logic       ext_rst_req,
  input logic       tick_ms,
  input logic       bus_wr,
  input logic [7:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       rst_out,
  input logic       sw_fire,
  input logic       seq_open,
  input logic       seq_armed,
  input logic [7:0] reg_val
);

  p_fire_needs_gate_r2: assert property (@(posedge clk) disable iff (!arst_n)
    sw_fire |-> seq_open);

  p_fire_starts_reset_r5: assert property (@(posedge clk) disable iff (!arst_n)
    sw_fire |=> (rst_out && reg_val == 8'hFF));

  p_nonff_no_reset_r6: assert property (@(posedge clk) disable iff (!arst_n)
    (bus_wr && bus_addr == FIRE_ADDR && bus_wdata != 8'hFF && !rst_out && !ext_rst_req)
      |=> !rst_out);

  p_end_on_tick_r7: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(rst_out) |-> $past(tick_ms));

  p_clear_on_end_r8: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(rst_out) |-> (reg_val == 8'h00));

  p_ff_only_in_reset_r8: assert property (@(posedge clk) disable iff (!arst_n)
    (reg_val == 8'hFF) |-> rst_out);

  p_ext_holds_r9: assert property (@(posedge clk) disable iff (!arst_n)
    ext_rst_req |=> rst_out);

  p_seq_clear_active_r10: assert property (@(posedge clk) disable iff (!arst_n)
    rst_out |-> !seq_armed);

endmodule

bind swrst_gen swrst_gen_chk #(.FIRE_ADDR(FIRE_ADDR)) u_chk (
  .clk         (clk),
  .arst_n      (arst_n),
  .ext_rst_req (ext_rst_req),
  .tick_ms     (tick_ms),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .rst_out     (rst_out),
  .sw_fire     (sw_fire),
  .seq_open    (seq_open),
  .seq_armed   (seq_armed),
  .reg_val     (reg_val)
);

// File: tb/sim_swrst_gen.sv
`timescale 1ns/100ps
module sim_swrst_gen;

  localparam logic [7:0] KA = 8'hC5;
  localparam logic [7:0] FA = 8'hC6;
  localparam logic [7:0] OA = 8'h3C;

  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic       ext_rst_req = 1'b0;
  logic       tick_ms = 1'b0;
  logic [2:0] dur_sel = 3'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_addr = FA;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       rst_out;

  int checks = 0;
  int errors = 0;
  bit summary_done = 1'b0;
  int divcnt = 0;
  int ms_of [8] = '{25, 200, 100, 50, 16, 8, 4, 2};

  always #2.5 clk = ~clk;

  swrst_gen #(.KEY_ADDR(KA), .FIRE_ADDR(FA)) u0 (
    .clk(clk), .arst_n(arst_n), .ext_rst_req(ext_rst_req), .tick_ms(tick_ms),
    .dur_sel(dur_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rst_out(rst_out)
  );

  // Tick on every fourth clock edge, changed away from the rising edge.
  always @(negedge clk) begin
    divcnt  <= (divcnt + 1) % 4;
    tick_ms <= (divcnt == 3);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = FA;
  endtask

  task automatic unlock();
    wr(KA, 8'h55); wr(KA, 8'hAA); wr(KA, 8'h5A);
  endtask

  // Called at a falling edge; counts tick edges taken while rst_out is high.
  task automatic measure(input logic [7:0] reg_exp, input string req, output int n);
    bit reg_ok = 1'b1;
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      #1;
      if (!rst_out) break;
      if (bus_rdata !== reg_exp) reg_ok = 1'b0;
      if (tick_ms) n++;
      @(negedge clk);
    end
    chk(reg_ok, req, bus_rdata, reg_exp);
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic t_power_on();
    int n;
    chk(rst_out === 1'b1, "R1", rst_out, 1);
    idle(3);
    arst_n = 1'b1;
    measure(8'h00, "R1", n);
    chk(n == 25, "R1", n, 25);
    #1 chk(bus_rdata === 8'h00, "R1", bus_rdata, 0);
  endtask

  task automatic t_locked();
    wr(FA, 8'hFF);
    #1 chk(rst_out === 1'b0, "R3", rst_out, 0);
    chk(bus_rdata === 8'h00, "R3", bus_rdata, 0);
  endtask

  task automatic t_fire(input int sel);
    int n;
    dur_sel = 3'(sel);
    unlock();
    wr(FA, 8'hFF);
    chk(rst_out === 1'b1, "R5", rst_out, 1);
    measure(8'hFF, "R5", n);
    chk(n == ms_of[sel], "R7", n, ms_of[sel]);
    #1 chk(bus_rdata === 8'h00, "R8", bus_rdata, 0);
  endtask

  task automatic t_nonff();
    dur_sel = 3'd7;
    unlock();
    wr(FA, 8'hFE);
    #1 chk(rst_out === 1'b0 && bus_rdata === 8'h00, "R6", bus_rdata, 0);
    wr(FA, 8'hFF);
    #1 chk(rst_out === 1'b0, "R6", rst_out, 0);
  endtask

  task automatic t_bad_seq();
    int n;
    dur_sel = 3'd7;
    wr(KA, 8'h55); wr(KA, 8'h12); wr(KA, 8'hAA); wr(KA, 8'h5A);
    wr(FA, 8'hFF);
    #1 chk(rst_out === 1'b0, "R4", rst_out, 0);
    wr(KA, 8'h55); wr(KA, 8'hAA); wr(KA, 8'hAA); wr(KA, 8'h5A);
    wr(FA, 8'hFF);
    #1 chk(rst_out === 1'b0, "R4", rst_out, 0);
    wr(KA, 8'h55); wr(KA, 8'h55); wr(KA, 8'hAA); wr(KA, 8'h5A);
    wr(FA, 8'hFF);
    chk(rst_out === 1'b1, "R4", rst_out, 1);
    measure(8'hFF, "R4", n);
  endtask

  task automatic t_other_addr();
    int n;
    dur_sel = 3'd6;
    wr(KA, 8'h55); wr(OA, 8'h00); wr(FA, 8'hFF); wr(KA, 8'hAA);
    wr(OA, 8'h5A); wr(KA, 8'h5A); wr(OA, 8'hFF);
    #1 chk(rst_out === 1'b0, "R11", rst_out, 0);
    wr(FA, 8'hFF);
    chk(rst_out === 1'b1, "R11", rst_out, 1);
    measure(8'hFF, "R11", n);
    chk(n == 4, "R11", n, 4);
  endtask

  task automatic t_ext();
    int n;
    dur_sel = 3'd5;
    @(negedge clk); ext_rst_req = 1'b1;
    idle(1);
    #1 chk(rst_out === 1'b1, "R9", rst_out, 1);
    idle(20);
    ext_rst_req = 1'b0;
    measure(8'h00, "R9", n);
    chk(n == 8, "R9", n, 8);
  endtask

  task automatic t_active_clear();
    int n;
    dur_sel = 3'd7;
    unlock();
    @(negedge clk); ext_rst_req = 1'b1;
    @(negedge clk); ext_rst_req = 1'b0;
    wr(KA, 8'h55);
    measure(8'h00, "R10", n);
    wr(FA, 8'hFF);
    #1 chk(rst_out === 1'b0, "R10", rst_out, 0);
    wr(KA, 8'hAA); wr(KA, 8'h5A); wr(FA, 8'hFF);
    #1 chk(rst_out === 1'b0, "R10", rst_out, 0);
  endtask

  task automatic t_coincide();
    int n;
    dur_sel = 3'd6;
    unlock();
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = FA; bus_wdata = 8'hFF; ext_rst_req = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; ext_rst_req = 1'b0;
    measure(8'hFF, "R9", n);
    chk(n == 4, "R9", n, 4);
    #1 chk(bus_rdata === 8'h00, "R8", bus_rdata, 0);
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5ns * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_power_on();
    t_locked();
    for (int s = 0; s < 8; s++) t_fire(s);
    t_nonff();
    t_bad_seq();
    t_other_addr();
    t_ext();
    t_active_clear();
    t_coincide();
    idle(4);
    finish_run();
  end

endmodule